// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block sits between one core and a snooping bus shared with other cores. It owns a small direct-mapped data cache and keeps a MESI state for every line: Invalid, Shared, Exclusive or Modified. The core issues loads, stores and atomic read-modify-write (RMW) reads. The bus side fetches lines with read-shared or read-for-ownership (RFO) requests, and writes back dirty victims. The block also answers snoops from other cores by downgrading, invalidating or supplying dirty data.

A core request is held stable until `resp_valid` is seen. Hits complete in the cycle they are presented. A miss walks the control machine through IDLE, then EVICT when a dirty victim must be written back, then FETCH. On the fill it returns to IDLE, and the request then completes as a hit. The EVICT to FETCH transition fires on the write-back response. The FETCH to IDLE transition fires on the fill response. Snoops are latched and answered only while the machine is in IDLE.

For atomics, the core raises `core_lock` around an RMW read and its following store. While the lock is held, a snoop that hits a Modified line waits until the lock drops, so the answer carries the committed value.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, no response, bus request or snoop acknowledge is active, and the first load to any address issues a bus request.
- R2: A load that hits a line in Modified, Exclusive or Shared asserts `resp_valid` with the line data in the same cycle, and issues no bus request.
- R3: A load miss issues read-shared (command 1). The line fills Exclusive when `bus_resp_shared` is low and Shared when it is high. A later store distinguishes the two: it is silent on Exclusive and needs an RFO on Shared.
- R4: A store (op 1) to an Exclusive or Modified line writes its data and leaves the line Modified, with no bus traffic.
- R5: A store to a Shared or Invalid line issues RFO (command 2). The store completes only after the RFO response has arrived.
- R6: A snooped read-shared (snoop command 1) that hits a Modified line acknowledges with hit and write-back set and supplies the line data. The line becomes Shared.
- R7: A snooped RFO (snoop command 2) that hits a valid line acknowledges with hit set and invalidates the line. Write-back is set with the data only when the line was Modified.
- R8: After a snooped RFO has invalidated a line, a load to it misses and returns the data fetched from the bus, not the old copy.
- R9: An RMW read (op 2) returns the line data and leaves the line Modified. It is silent from Exclusive and issues RFO from Shared or Invalid. While `core_lock` is high, a snoop hitting a Modified line is not acknowledged. Once the lock drops, the acknowledge carries the value stored under the lock.
- R10: Only one bus transaction is outstanding at a time, and its request is held until its response. A snoop is acknowledged exactly one cycle after it is first presented when the controller is idle and not blocked. A snoop that misses acknowledges with hit clear.
- R11: A miss whose index holds a Modified line of another tag first issues a write-back (command 3) of that line's address and data, then the fetch. Clean victims are dropped without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present, held until resp_valid |
| req_op | input | 2 | 0 load, 1 store, 2 RMW read, 3 ignored |
| req_addr | input | IDX_W+TAG_W | Word address {tag, index} |
| req_wdata | input | DATA_W | Store data |
| core_lock | input | 1 | Holds Modified lines against snoops during an RMW |
| resp_valid | output | 1 | Request completes this cycle |
| resp_rdata | output | DATA_W | Line data for load and RMW |
| bus_req_valid | output | 1 | Bus request active |
| bus_req_cmd | output | 2 | 1 read-shared, 2 RFO, 3 write-back |
| bus_req_addr | output | IDX_W+TAG_W | Bus request address |
| bus_req_data | output | DATA_W | Write-back data |
| bus_resp_valid | input | 1 | Bus response pulse |
| bus_resp_data | input | DATA_W | Fill data |
| bus_resp_shared | input | 1 | Another cache keeps a copy |
| snoop_valid | input | 1 | Snoop presented, held until snoop_ack |
| snoop_cmd | input | 2 | 1 read-shared, 2 RFO |
| snoop_addr | input | IDX_W+TAG_W | Snooped address |
| snoop_ack | output | 1 | Snoop answered this cycle |
| snoop_hit | output | 1 | A valid copy was found |
| snoop_wb | output | 1 | Dirty data supplied on snoop_data |
| snoop_data | output | DATA_W | Line data for the snoop |

## Verification
The bench builds the block with its defaults: four lines, a four-bit tag and eight-bit data. This keeps several tags per index within reach, so victim write-back, clean eviction and refetch after invalidation all occur within a few requests. A behavioural memory answers the bus with a latency the bench can raise. This brings a snoop that arrives during an outstanding fetch, and the lock window around an RMW, within reach of directed tests.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_RMW = 2'd2, OP_NONE = 2'd3} core_op_e;
    typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_RDSH = 2'd1, BUS_RFO = 2'd2, BUS_WB = 2'd3} bus_cmd_e;
    typedef enum logic [1:0] {CT_IDLE = 2'd0, CT_EVICT = 2'd1, CT_FETCH = 2'd2} ctrl_st_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [TAG_W-1:0]  a_tag,
    output line_st_e          a_st,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [TAG_W-1:0]  b_tag,
    output line_st_e          b_st,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_st_e          wr_st,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q  [LINES];
    line_st_e          st_q   [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]   <= ST_I;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                st_q[i]   <= wr_st;
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    assign a_tag  = tag_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_st   = st_q[b_idx];
    assign b_data = data_q[b_idx];
endmodule

// File: rtl/mesi_snoop_latch.sv
module mesi_snoop_latch #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              fire,
    output logic              pend,
    output logic [1:0]        pend_cmd,
    output logic [ADDR_W-1:0] pend_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_cmd  <= '0;
            pend_addr <= '0;
        end else if (fire) begin
            pend <= 1'b0;
        end else if (snoop_valid && !pend) begin
            pend      <= 1'b1;
            pend_cmd  <= snoop_cmd;
            pend_addr <= snoop_addr;
        end
    end
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [IDX_W+TAG_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   core_lock,
    output logic                   resp_valid,
    output logic [DATA_W-1:0]      resp_rdata,
    output logic                   bus_req_valid,
    output logic [1:0]             bus_req_cmd,
    output logic [IDX_W+TAG_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0]      bus_req_data,
    input  logic                   bus_resp_valid,
    input  logic [DATA_W-1:0]      bus_resp_data,
    input  logic                   bus_resp_shared,
    input  logic                   snoop_valid,
    input  logic [1:0]             snoop_cmd,
    input  logic [IDX_W+TAG_W-1:0] snoop_addr,
    output logic                   snoop_ack,
    output logic                   snoop_hit,
    output logic                   snoop_wb,
    output logic [DATA_W-1:0]      snoop_data
);
    localparam int ADDR_W = IDX_W + TAG_W;

    ctrl_st_e ctl_q, ctl_d;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  a_tag, b_tag;
    line_st_e          a_st, b_st;
    logic [DATA_W-1:0] a_data, b_data;

    logic              snp_pend, snp_fire;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic [IDX_W-1:0]  snp_idx;
    logic              snp_hit, snp_block, req_hit, req_load;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    line_st_e          wr_st;
    logic [DATA_W-1:0] wr_data;

    assign req_idx   = req_addr[IDX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:IDX_W];
    assign req_load  = (req_op == OP_LOAD);
    assign req_hit   = (a_st != ST_I) && (a_tag == req_tag);
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_hit   = (b_st != ST_I) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign snp_block = core_lock && snp_hit && (b_st == ST_M);
    assign resp_rdata = a_data;
    assign snoop_data = b_data;

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(req_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
        .b_idx(snp_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st), .wr_data(wr_data)
    );

    mesi_snoop_latch #(.ADDR_W(ADDR_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .fire(snp_fire), .pend(snp_pend), .pend_cmd(snp_cmd), .pend_addr(snp_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CT_IDLE;
        else        ctl_q <= ctl_d;
    end

    // Next state, outputs and line-store write port
    always_comb begin
        ctl_d         = ctl_q;
        resp_valid    = 1'b0;
        bus_req_valid = 1'b0;
        bus_req_cmd   = BUS_NONE;
        bus_req_addr  = req_addr;
        bus_req_data  = '0;
        snoop_ack     = 1'b0;
        snoop_hit     = 1'b0;
        snoop_wb      = 1'b0;
        snp_fire      = 1'b0;
        wr_en         = 1'b0;
        wr_idx        = req_idx;
        wr_tag        = a_tag;
        wr_st         = a_st;
        wr_data       = a_data;
        unique case (ctl_q)
            CT_IDLE: begin
                if (snp_pend && !snp_block) begin
                    snp_fire  = 1'b1;
                    snoop_ack = 1'b1;
                    snoop_hit = snp_hit;
                    snoop_wb  = snp_hit && (b_st == ST_M);
                    if (snp_hit) begin
                        wr_en   = 1'b1;
                        wr_idx  = snp_idx;
                        wr_tag  = b_tag;
                        wr_data = b_data;
                        wr_st   = (snp_cmd == BUS_RFO) ? ST_I : ST_S;
                    end
                end else if (req_valid && req_op != OP_NONE) begin
                    if (req_hit && (req_load || a_st == ST_M || a_st == ST_E)) begin
                        resp_valid = 1'b1;
                        if (!req_load) begin
                            wr_en   = 1'b1;
                            wr_st   = ST_M;
                            wr_data = (req_op == OP_STORE) ? req_wdata : a_data;
                        end
                    end else if (a_st == ST_M && a_tag != req_tag) begin
                        ctl_d = CT_EVICT;
                    end else begin
                        ctl_d = CT_FETCH;
                    end
                end
            end
            CT_EVICT: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BUS_WB;
                bus_req_addr  = {a_tag, req_idx};
                bus_req_data  = a_data;
                if (bus_resp_valid) ctl_d = CT_FETCH;
            end
            CT_FETCH: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = req_load ? BUS_RDSH : BUS_RFO;
                if (bus_resp_valid) begin
                    wr_en   = 1'b1;
                    wr_tag  = req_tag;
                    wr_data = bus_resp_data;
                    wr_st   = !req_load ? ST_M : (bus_resp_shared ? ST_S : ST_E);
                    ctl_d   = CT_IDLE;
                end
            end
            default: ctl_d = CT_IDLE;
        endcase
    end
endmodule

// File: rtl/mesi_coh_ctrl_sva.sv
module mesi_coh_ctrl_sva #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_lock,
    input logic              resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_resp_valid,
    input logic              snoop_valid,
    input logic              snoop_ack,
    input logic              snoop_hit,
    input logic              snoop_wb
);
    // R10: an unanswered bus request stays up with the same command and address
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_resp_valid |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr));

    // R10: snoops are not answered while a bus transaction is outstanding
    p_no_snoop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !snoop_ack);

    // R10: an acknowledge only follows a presented snoop
    p_ack_after_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack |-> $past(snoop_valid));

    // R2: a completing request never coincides with bus traffic
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !bus_req_valid);

    // R7: dirty data is only supplied by a hitting snoop
    p_wb_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack && snoop_wb |-> snoop_hit);

    // R9: under the lock no Modified line is given up
    p_lock_keeps_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_lock && snoop_ack |-> !snoop_wb);
endmodule

bind mesi_coh_ctrl mesi_coh_ctrl_sva #(.ADDR_W(IDX_W + TAG_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .core_lock(core_lock), .resp_valid(resp_valid),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_resp_valid(bus_resp_valid), .snoop_valid(snoop_valid), .snoop_ack(snoop_ack),
    .snoop_hit(snoop_hit), .snoop_wb(snoop_wb)
);

// File: tb/mesi_coh_ctrl_tb.sv
module mesi_coh_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       core_lock = 1'b0;
    logic       resp_valid;
    logic [7:0] resp_rdata;
    logic       bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [5:0] bus_req_addr;
    logic [7:0] bus_req_data;
    logic       bus_resp_valid = 1'b0;
    logic [7:0] bus_resp_data = '0;
    logic       bus_resp_shared = 1'b0;
    logic       snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = '0;
    logic [5:0] snoop_addr = '0;
    logic       snoop_ack, snoop_hit, snoop_wb;
    logic [7:0] snoop_data;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int wait_cnt = 0;
    int bus_count = 0;
    logic [1:0] last_cmd = '0;
    logic other_shared = 1'b0;
    logic [7:0] mem [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mesi_coh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .core_lock(core_lock), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .bus_req_data(bus_req_data), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_resp_shared(bus_resp_shared), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
        .snoop_addr(snoop_addr), .snoop_ack(snoop_ack), .snoop_hit(snoop_hit), .snoop_wb(snoop_wb),
        .snoop_data(snoop_data)
    );

    // Behavioural shared level: answers one request after lat+1 negedges
    always @(negedge clk) begin
        if (bus_resp_valid) begin
            bus_resp_valid = 1'b0;
        end else if (bus_req_valid) begin
            if (wait_cnt >= lat) begin
                wait_cnt = 0;
                bus_count++;
                last_cmd = bus_req_cmd;
                if (bus_req_cmd == 2'd3) mem[bus_req_addr] = bus_req_data;
                else bus_resp_data = mem[bus_req_addr];
                bus_resp_shared = other_shared;
                bus_resp_valid = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_core(input logic [1:0] op, input logic [5:0] addr, input logic [7:0] wd,
                           input logic sh, output logic [7:0] rd, output int nbus);
        int start;
        start = bus_count;
        other_shared = sh;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        forever begin
            #1;
            if (resp_valid) break;
            @(negedge clk);
        end
        rd = resp_rdata;
        nbus = bus_count - start;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic [5:0] addr, output int dly,
                            output logic hit, output logic wb, output logic [7:0] data);
        @(negedge clk);
        #1;
        snoop_valid = 1'b1; snoop_cmd = cmd; snoop_addr = addr;
        dly = 0;
        forever begin
            @(negedge clk);
            #1;
            dly++;
            if (snoop_ack) break;
        end
        hit = snoop_hit; wb = snoop_wb; data = snoop_data;
        if (wb) mem[addr] = data;
        snoop_valid = 1'b0;
    endtask

    // {op, addr, wdata, shared, expected data, bus transactions, last bus command}
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 6'h05, 8'h00, 1'b0, 8'h10, 3'd1, 2'd1},
        {2'd0, 6'h05, 8'h00, 1'b0, 8'h10, 3'd0, 2'd0},
        {2'd1, 6'h05, 8'hA5, 1'b0, 8'h00, 3'd0, 2'd0},
        {2'd0, 6'h05, 8'h00, 1'b0, 8'hA5, 3'd0, 2'd0},
        {2'd0, 6'h06, 8'h00, 1'b1, 8'h13, 3'd1, 2'd1},
        {2'd1, 6'h06, 8'h3C, 1'b0, 8'h00, 3'd1, 2'd2},
        {2'd0, 6'h06, 8'h00, 1'b0, 8'h3C, 3'd0, 2'd0},
        {2'd0, 6'h09, 8'h00, 1'b0, 8'h1C, 3'd2, 2'd1},
        {2'd0, 6'h05, 8'h00, 1'b0, 8'hA5, 3'd1, 2'd1},
        {2'd0, 6'h01, 8'h00, 1'b1, 8'h04, 3'd1, 2'd1},
        {2'd0, 6'h01, 8'h00, 1'b0, 8'h04, 3'd0, 2'd0},
        {2'd1, 6'h0B, 8'h77, 1'b0, 8'h00, 3'd1, 2'd2},
        {2'd0, 6'h0B, 8'h00, 1'b0, 8'h77, 3'd0, 2'd0},
        {2'd2, 6'h0A, 8'h00, 1'b0, 8'h1F, 3'd2, 2'd2}
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd, sd;
        int nb, dly;
        logic h, w;
        string tag;
        for (int a = 0; a < 64; a++) mem[a] = 8'(3 * a + 1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk("R1 resp_valid", 32'(resp_valid), 0);
        chk("R1 bus_req_valid", 32'(bus_req_valid), 0);
        chk("R1 snoop_ack", 32'(snoop_ack), 0);

        for (int i = 0; i < NV; i++) begin
            do_core(VEC[i][29:28], VEC[i][27:22], VEC[i][21:14], VEC[i][13], rd, nb);
            if (VEC[i][4:2] == 3'd2) tag = "R11";
            else if (VEC[i][29:28] == 2'd2) tag = "R9";
            else if (VEC[i][29:28] == 2'd1) tag = (nb == 0) ? "R4" : "R5";
            else if (i == 0) tag = "R1";
            else tag = (VEC[i][4:2] == 3'd0) ? "R2" : "R3";
            if (VEC[i][29:28] != 2'd1)
                chk($sformatf("%s data vec %0d", tag, i), 32'(rd), 32'(VEC[i][12:5]));
            chk($sformatf("%s bus count vec %0d", tag, i), 32'(nb), 32'(VEC[i][4:2]));
            if (VEC[i][4:2] != 3'd0)
                chk($sformatf("%s bus cmd vec %0d", tag, i), 32'(last_cmd), 32'(VEC[i][1:0]));
        end
        chk("R11 victim written back", 32'(mem[6]), 32'h3C);

        // R6: read-shared snoop on a Modified line
        do_snoop(2'd1, 6'h0B, dly, h, w, sd);
        chk("R10 snoop ack delay", 32'(dly), 1);
        chk("R6 snoop hit", 32'(h), 1);
        chk("R6 snoop wb", 32'(w), 1);
        chk("R6 snoop data", 32'(sd), 32'h77);
        do_core(2'd0, 6'h0B, 8'h00, 1'b0, rd, nb);
        chk("R6 load hit after downgrade", 32'(nb), 0);
        do_core(2'd1, 6'h0B, 8'h78, 1'b0, rd, nb);
        chk("R6 store on Shared needs RFO", 32'(last_cmd), 2);
        chk("R6 store bus count", 32'(nb), 1);

        // R7 / R8: RFO snoop invalidates, reload is fresh
        do_snoop(2'd2, 6'h0B, dly, h, w, sd);
        chk("R7 rfo snoop wb", 32'(w), 1);
        chk("R7 rfo snoop data", 32'(sd), 32'h78);
        mem[11] = 8'h99;
        do_core(2'd0, 6'h0B, 8'h00, 1'b0, rd, nb);
        chk("R8 reload data", 32'(rd), 32'h99);
        chk("R8 reload misses", 32'(nb), 1);
        do_snoop(2'd1, 6'h0B, dly, h, w, sd);
        chk("R7 share snoop on Exclusive no wb", 32'({h, w}), 32'b10);
        do_snoop(2'd2, 6'h0B, dly, h, w, sd);
        chk("R7 rfo snoop on Shared", 32'({h, w}), 32'b10);
        do_core(2'd0, 6'h0B, 8'h00, 1'b0, rd, nb);
        chk("R8 miss after Shared invalidate", 32'(nb), 1);
        do_snoop(2'd1, 6'h3F, dly, h, w, sd);
        chk("R10 miss snoop", 32'({h, w}), 0);
        chk("R10 miss snoop delay", 32'(dly), 1);

        // R9: lock holds off a snoop until the store has committed
        core_lock = 1'b1;
        do_core(2'd2, 6'h0A, 8'h00, 1'b0, rd, nb);
        chk("R9 rmw on Modified data", 32'(rd), 32'h1F);
        chk("R9 rmw on Modified quiet", 32'(nb), 0);
        fork
            do_snoop(2'd2, 6'h0A, dly, h, w, sd);
            begin
                repeat (4) @(negedge clk);
                #2 chk("R9 no ack under lock", 32'(snoop_ack), 0);
                do_core(2'd1, 6'h0A, 8'h32, 1'b0, rd, nb);
                core_lock = 1'b0;
            end
        join
        chk("R9 snoop delayed", 32'(dly > 3), 1);
        chk("R9 snoop wb", 32'(w), 1);
        chk("R9 snoop sees committed value", 32'(sd), 32'h32);

        // R9: RMW from Exclusive is silent and lands in Modified
        do_core(2'd0, 6'h0C, 8'h00, 1'b0, rd, nb);
        do_core(2'd2, 6'h0C, 8'h00, 1'b0, rd, nb);
        chk("R9 rmw on Exclusive data", 32'(rd), 32'h25);
        chk("R9 rmw on Exclusive quiet", 32'(nb), 0);
        do_snoop(2'd1, 6'h0C, dly, h, w, sd);
        chk("R9 line is Modified after rmw", 32'(w), 1);

        // R10: snoop during an outstanding fetch waits for idle
        lat = 4;
        fork
            do_core(2'd0, 6'h21, 8'h00, 1'b0, rd, nb);
            begin
                @(negedge clk);
                do_snoop(2'd1, 6'h0C, dly, h, w, sd);
            end
        join
        chk("R10 busy load data", 32'(rd), 32'h64);
        chk("R10 snoop waited", 32'(dly > 1), 1);
        chk("R10 snoop result", 32'({h, w}), 32'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule